// File: doc/BRIEF.md
# Registered-I/O Synchronous SRAM with Pass-Through

This block is a single-clock static memory with separate input and output data ports. Every rising clock edge captures the address, the write data, an active-low chip select, an active-low write strobe and an active-low output enable. On the next edge the captured cycle is carried out. The array may be written, the captured input word may be forwarded to the output register, or a stored word may be read into it. The result is visible after that second edge.

The chip select never deselects the memory. A high chip select only blocks the array write and turns the cycle into a pass-through, so the input word is forwarded to the output register. The only thing that disables the outputs is the registered output enable. Instead of a three-state pin, the output is a data word plus a valid flag. The output register loads its word whether or not the outputs are enabled.

The captured control pair is held as an enumerated operation state with three values. `ST_WRITE` is a write with pass-through, `ST_PASS` is a pass-through with no write, and `ST_READ` is an array read. The state goes to `ST_PASS` on reset. On every edge it moves to the state that the current chip select and write strobe decode to. Chip select high gives `ST_PASS`. Chip select low with the write strobe low gives `ST_WRITE`. Chip select low with the write strobe high gives `ST_READ`. Every state can reach every other state in one edge.

Top module: `regio_sram`

## Requirements
- R1: All inputs are captured on a rising clock edge. The result of the cycle captured at edge n appears on `dout_o`/`dout_vld_o` after edge n+1.
- R2: With `cs_n_i`=0 and `we_n_i`=0 captured, the word on `din_i` is written at the captured address. The same word appears on `dout_o`.
- R3: With `cs_n_i`=1 captured, the array is not written, whatever `we_n_i` is. The captured `din_i` word appears on `dout_o`.
- R4: With `cs_n_i`=0 and `we_n_i`=1 captured, the stored word at the captured address appears on `dout_o`.
- R5: `dout_vld_o` is 1 exactly when the captured `oe_n_i` for that output cycle was 0. `cs_n_i` has no effect on it.
- R6: A write captured with `oe_n_i`=1 still updates the array. A later read returns the new word.
- R7: While the outputs are disabled, `dout_o` still carries the word that the cycle would have presented.
- R8: An asynchronous active-low reset clears `dout_vld_o` to 0 and sets the operation state to `ST_PASS` with the output enable off. No array write happens during reset or on the first edge after it.
- R9: A read captured on the edge right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Write / pass-through data |
| cs_n_i | input | 1 | Chip select, active low; high blocks the write and forces pass-through |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dout_o | output | DATA_W | Output register word |
| dout_vld_o | output | 1 | Output enabled (replaces three-state drive) |

## Verification
The properties assume that the inputs are stable around the rising edge. They also assume that two clean edges have passed since reset was released before any data comparison starts, and a counter in the checker enforces that wait. The bench drives every input on the falling edge and releases reset on a falling edge, so each input is captured by exactly one rising edge. No reads are made of addresses that have never been written, so no data check depends on array contents left undefined after reset.

// File: rtl/regio_sram_pkg.sv
package regio_sram_pkg;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic cs_n, input logic we_n);
        if (cs_n)
            return ST_PASS;
        else if (we_n)
            return ST_READ;
        else
            return ST_WRITE;
    endfunction

endpackage

// File: rtl/regio_sram_inreg.sv
module regio_sram_inreg
    import regio_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q,
    output logic              oe_n_q
);

    op_e op_next;

    always_comb begin
        op_next = decode_op(cs_n_i, we_n_i);
    end

    // operation state register plus captured address/data/enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= ST_PASS;
            addr_q <= '0;
            din_q  <= '0;
            oe_n_q <= 1'b1;
        end else begin
            op_q   <= op_next;
            addr_q <= addr_i;
            din_q  <= din_i;
            oe_n_q <= oe_n_i;
        end
    end

endmodule

// File: rtl/regio_sram_array.sv
module regio_sram_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[addr] <= wr_data;
    end

    always_comb begin
        rd_data = mem[addr];
    end

endmodule

// File: rtl/regio_sram_outreg.sv
module regio_sram_outreg
    import regio_sram_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_q,
    input  logic [DATA_W-1:0] din_q,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              oe_n_q,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_vld_o
);

    logic [DATA_W-1:0] dout_next;

    // output selection per operation state
    always_comb begin
        dout_next = din_q;
        unique case (op_q)
            ST_WRITE: dout_next = din_q;
            ST_PASS:  dout_next = din_q;
            ST_READ:  dout_next = rd_data;
            default:  dout_next = din_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_o     <= '0;
            dout_vld_o <= 1'b0;
        end else begin
            dout_o     <= dout_next;
            dout_vld_o <= ~oe_n_q;
        end
    end

endmodule

// File: rtl/regio_sram.sv
module regio_sram
    import regio_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_vld_o
);

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic              oe_n_q;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;

    regio_sram_inreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_inreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr_i),
        .din_i  (din_i),
        .cs_n_i (cs_n_i),
        .we_n_i (we_n_i),
        .oe_n_i (oe_n_i),
        .op_q   (op_q),
        .addr_q (addr_q),
        .din_q  (din_q),
        .oe_n_q (oe_n_q)
    );

    // array write only from the write state; gated by reset so nothing lands while held
    always_comb begin
        wr_en = rst_n && (op_q == ST_WRITE);
    end

    regio_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .addr    (addr_q),
        .wr_data (din_q),
        .rd_data (rd_data)
    );

    regio_sram_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_q       (op_q),
        .din_q      (din_q),
        .rd_data    (rd_data),
        .oe_n_q     (oe_n_q),
        .dout_o     (dout_o),
        .dout_vld_o (dout_vld_o)
    );

endmodule

// File: rtl/regio_sram_chk.sv
module regio_sram_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din_i,
    input logic              cs_n_i,
    input logic              we_n_i,
    input logic              oe_n_i,
    input logic [DATA_W-1:0] dout_o,
    input logic              dout_vld_o
);

    logic [1:0] edges_since_rst;
    logic       rst_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            edges_since_rst <= 2'd0;
        else if (edges_since_rst != 2'd2)
            edges_since_rst <= edges_since_rst + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_seen <= 1'b1;
    end

    // R5: output valid follows the enable captured two edges earlier
    p_vld_tracks_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_since_rst == 2'd2) |-> (dout_vld_o == !$past(oe_n_i, 2)));

    // R3: chip select high forwards the input word
    p_pass_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_since_rst == 2'd2 && $past(cs_n_i, 2)) |-> (dout_o == $past(din_i, 2)));

    // R2: write cycle also forwards the written word
    p_write_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_since_rst == 2'd2 && !$past(cs_n_i, 2) && !$past(we_n_i, 2))
        |-> (dout_o == $past(din_i, 2)));

    // R8: outputs stay disabled while reset is held
    p_reset_quiet_r8: assert property (@(posedge clk)
        (!rst_n && rst_seen) |-> !dout_vld_o);

endmodule

bind regio_sram regio_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .din_i      (din_i),
    .cs_n_i     (cs_n_i),
    .we_n_i     (we_n_i),
    .oe_n_i     (oe_n_i),
    .dout_o     (dout_o),
    .dout_vld_o (dout_vld_o)
);

// File: tb/tb_regio_sram.sv
module tb_regio_sram;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 9;
    localparam int NVEC   = 17;

    logic              clk;
    logic              rst_n;
    logic [ADDR_W-1:0] addr_i;
    logic [DATA_W-1:0] din_i;
    logic              cs_n_i;
    logic              we_n_i;
    logic              oe_n_i;
    logic [DATA_W-1:0] dout_o;
    logic              dout_vld_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    regio_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .din_i      (din_i),
        .cs_n_i     (cs_n_i),
        .we_n_i     (we_n_i),
        .oe_n_i     (oe_n_i),
        .dout_o     (dout_o),
        .dout_vld_o (dout_vld_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // {req[3:0], cs_n, we_n, oe_n, addr[3:0], din[8:0], chk, exp_vld, exp_dout[8:0]}
    localparam logic [30:0] VEC [NVEC] = '{
        {4'd2, 1'b0, 1'b0, 1'b0, 4'd3, 9'h0A5, 1'b1, 1'b1, 9'h0A5}, // R2 write+pass
        {4'd2, 1'b0, 1'b0, 1'b0, 4'd5, 9'h15A, 1'b1, 1'b1, 9'h15A}, // R2
        {4'd4, 1'b0, 1'b1, 1'b0, 4'd3, 9'h000, 1'b1, 1'b1, 9'h0A5}, // R4 read
        {4'd3, 1'b1, 1'b0, 1'b0, 4'd3, 9'h1FF, 1'b1, 1'b1, 9'h1FF}, // R3 pass, write blocked
        {4'd3, 1'b0, 1'b1, 1'b0, 4'd3, 9'h000, 1'b1, 1'b1, 9'h0A5}, // R3 a3 unchanged
        {4'd7, 1'b0, 1'b0, 1'b1, 4'd7, 9'h033, 1'b1, 1'b0, 9'h033}, // R7 disabled, word loaded
        {4'd6, 1'b0, 1'b1, 1'b0, 4'd7, 9'h000, 1'b1, 1'b1, 9'h033}, // R6 write under oe high
        {4'd3, 1'b1, 1'b1, 1'b0, 4'd0, 9'h100, 1'b1, 1'b1, 9'h100}, // R3 pass with we high
        {4'd7, 1'b0, 1'b1, 1'b1, 4'd5, 9'h000, 1'b1, 1'b0, 9'h15A}, // R7 read while disabled
        {4'd2, 1'b0, 1'b0, 1'b0, 4'd9, 9'h0C3, 1'b1, 1'b1, 9'h0C3}, // R2
        {4'd9, 1'b0, 1'b1, 1'b0, 4'd9, 9'h000, 1'b1, 1'b1, 9'h0C3}, // R9 read right after write
        {4'd5, 1'b1, 1'b1, 1'b1, 4'd5, 9'h055, 1'b1, 1'b0, 9'h055}, // R5 cs high, oe high
        {4'd1, 1'b0, 1'b1, 1'b0, 4'd5, 9'h000, 1'b1, 1'b1, 9'h15A}, // R1 latency, read
        {4'd3, 1'b1, 1'b0, 1'b0, 4'd9, 9'h000, 1'b1, 1'b1, 9'h000}, // R3 pass zero
        {4'd3, 1'b0, 1'b1, 1'b0, 4'd9, 9'h000, 1'b1, 1'b1, 9'h0C3}, // R3 a9 unchanged
        {4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 9'h000, 1'b0, 1'b0, 9'h000}, // flush
        {4'd0, 1'b1, 1'b1, 1'b0, 4'd0, 9'h000, 1'b0, 1'b0, 9'h000}  // flush
    };

    task automatic check(input string req, input logic [DATA_W:0] act,
                         input logic [DATA_W:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got vld/dout=%h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic cs_n, input logic we_n, input logic oe_n,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        cs_n_i = cs_n;
        we_n_i = we_n;
        oe_n_i = oe_n;
        addr_i = a;
        din_i  = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, '0, '0);
        repeat (3) @(negedge clk);
        check("R8 reset state", {dout_vld_o, 9'h000}, {1'b0, 9'h000});
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            if (i >= 2 && VEC[i-2][10]) begin
                if (VEC[i-2][9])
                    check($sformatf("R%0d vec%0d", VEC[i-2][30:27], i-2),
                          {dout_vld_o, dout_o}, VEC[i-2][9:0]);
                else
                    check($sformatf("R%0d vec%0d", VEC[i-2][30:27], i-2),
                          {dout_vld_o, dout_o}, VEC[i-2][9:0]);
            end
            drive(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:20], VEC[i][19:11]);
            @(negedge clk);
        end

        // R8: asynchronous reset while outputs enabled, with a write pending
        check("R5 enabled before reset", {dout_vld_o, 9'h000}, {1'b1, 9'h000});
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 4'd3, 9'h1EE);
        #1;
        check("R8 async clear", {dout_vld_o, 9'h000}, {1'b0, 9'h000});
        @(negedge clk);
        check("R8 held in reset", {dout_vld_o, 9'h000}, {1'b0, 9'h000});
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 4'd3, 9'h000);
        @(negedge clk);
        check("R8 first cycle after reset", {dout_vld_o, 9'h000}, {1'b0, 9'h000});
        drive(1'b1, 1'b1, 1'b1, 4'd0, 9'h000);
        @(negedge clk);
        check("R8 no write during reset", {dout_vld_o, dout_o}, {1'b1, 9'h0A5});
        @(negedge clk);
        check("R5 disabled by oe", {dout_vld_o, 9'h000}, {1'b0, 9'h000});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule